// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets a clocked host read and write single bytes in an external 2048 x 8 asynchronous static RAM. The host offers a request with an address, a write flag and write data. The controller turns that request into a correctly timed strobe sequence on the memory's active-low chip enable, write enable and output enable. It drives the 8-bit data bus through a separate tri-state enable. Read data returns to the host as a registered byte with a one-cycle valid pulse.

All memory timing figures are parameters in nanoseconds. The clock period is a parameter too. Each figure becomes a cycle count by rounding up after division by the period, with a floor of one cycle.

A write is strobed by write enable. Output enable is kept high, and the bus turnaround time passes before the controller drives data. Address and data stay stable for a hold margin after the write strobe rises. After the power-good input rises, a hold-off passes before any access can begin.

Request flow control works as follows. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The host keeps its request fields steady until that edge. Request fields presented while `req_ready` is low are ignored. The response has no back-pressure: `rsp_valid` is high for exactly one cycle, and the host must take `rsp_rdata` in that cycle.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is asserted, mem_ce_n, mem_we_n and mem_oe_n are 1, and mem_dq_oe, req_ready and rsp_valid are 0.
- R2: req_ready stays 0, and mem_ce_n stays 1, until pwr_good has been 1 for PWR_CYC = ceil(T_PWRUP_NS / CLK_PERIOD_NS) consecutive rising edges. req_ready drops in the same cycle that pwr_good drops.
- R3: For an accepted read (req_write = 0), the outputs hold for ACC_CYC = ceil(T_ACC_NS / period) cycles starting at the accepting edge. During those cycles mem_ce_n = 0, mem_oe_n = 0, mem_we_n = 1, mem_dq_oe = 0 and mem_addr equals the request address. The byte on mem_dq_i at the last edge of that window appears on rsp_rdata, with rsp_valid = 1 for exactly one cycle.
- R4: For an accepted write (req_write = 1), the first TURN_CYC = ceil(max(T_AS_NS, T_OEZ_NS) / period) cycles hold mem_ce_n = 0, mem_oe_n = 1, mem_we_n = 1 and mem_dq_oe = 0.
- R5: The write strobe follows the turnaround. mem_we_n = 0 for exactly PULSE_CYC = ceil(max(T_WP_NS, T_DS_NS, T_CW_NS, T_AW_NS - T_AS_NS) / period) cycles. During the strobe mem_dq_oe = 1 and mem_dq_o equals the request data, and the memory stores that byte at the request address.
- R6: After mem_we_n rises, mem_ce_n = 0, mem_dq_oe = 1 and mem_addr stay unchanged for HOLD_CYC = ceil(max(T_DH_NS, T_AH_NS) / period) cycles. After that mem_ce_n returns to 1 and mem_dq_oe to 0.
- R7: mem_addr changes only on an accepting edge. It never changes while mem_we_n is 0.
- R8: req_ready is 0 from the accepting edge until the access has finished and CYC_CYC = ceil(T_RC_NS / period) cycles have passed since acceptance. Request inputs presented while req_ready is 0 cause no memory access.
- R9: mem_dq_oe is never 1 while mem_oe_n is 0.
- R10: Back-to-back requests in any mix of reads and writes return the byte most recently written to each address, including addresses 0 and 2047.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_good | input | 1 | Memory supply is at operating level |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 11 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle read data valid pulse |
| rsp_rdata | output | 8 | Read byte |
| mem_addr | output | 11 | Memory address lines |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_dq_o | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Tri-state driver enable for mem_dq_o |
| mem_dq_i | input | 8 | Data received from the memory bus |

## Verification
A phase counter that is wrong by one shows at once as a strobe window of the wrong length. The write-enable low time or the read latency in cycles is off, and the bench counts these at each negative edge after acceptance. A state decode that drifts would enable the data driver while output enable is low. That shows as contention within one cycle. It would also let the address move during the strobe, which lands the byte at the wrong location and is caught on the next read-back. A faulty cycle timer or power gate shows as req_ready rising early, which is seen in the very cycle it happens.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_READ   = 3'd1,
    ST_WTURN  = 3'd2,
    ST_WPULSE = 3'd3,
    ST_WHOLD  = 3'd4
  } ctl_state_e;

  // nanoseconds to whole clock cycles, rounded up, never below one
  function automatic int ns_to_cyc(input int ns, input int period);
    int c;
    c = (ns + period - 1) / period;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_cyc_timer.sv
module sram_cyc_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // R8
  timer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (zero && !load) |=> zero);

endmodule

// File: rtl/sram_pwr_gate.sv
module sram_pwr_gate #(
  parameter int HOLD_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  output logic pwr_ok
);

  localparam int W = $clog2(HOLD_CYC + 1);
  localparam logic [W-1:0] LIMIT = W'(HOLD_CYC);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!pwr_good)  cnt <= '0;
    else if (cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  assign pwr_ok = pwr_good && (cnt == LIMIT);

  // R2
  pwr_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_ok |-> $past(pwr_good));

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 11,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 20,
  parameter int T_RC_NS       = 70,
  parameter int T_ACC_NS      = 70,
  parameter int T_AS_NS       = 10,
  parameter int T_OEZ_NS      = 35,
  parameter int T_WP_NS       = 40,
  parameter int T_DS_NS       = 30,
  parameter int T_CW_NS       = 45,
  parameter int T_AW_NS       = 50,
  parameter int T_DH_NS       = 10,
  parameter int T_AH_NS       = 10,
  parameter int T_PWRUP_NS    = 55
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int P         = CLK_PERIOD_NS;
  localparam int CYC_CYC   = ns_to_cyc(T_RC_NS, P);
  localparam int ACC_CYC   = ns_to_cyc(T_ACC_NS, P);
  localparam int TURN_CYC  = ns_to_cyc(imax(T_AS_NS, T_OEZ_NS), P);
  localparam int PULSE_CYC = ns_to_cyc(imax(imax(T_WP_NS, T_DS_NS),
                                            imax(T_CW_NS, T_AW_NS - T_AS_NS)), P);
  localparam int HOLD_CYC  = ns_to_cyc(imax(T_DH_NS, T_AH_NS), P);
  localparam int PWR_CYC   = ns_to_cyc(T_PWRUP_NS, P);
  localparam int MAX_CYC   = imax(imax(CYC_CYC, ACC_CYC),
                                  imax(imax(TURN_CYC, PULSE_CYC), HOLD_CYC));
  localparam int CW        = $clog2(MAX_CYC + 1);

  ctl_state_e        st, nxt;
  logic              pwr_ok;
  logic              accept;
  logic              ph_load, ph_zero, cyc_zero;
  logic [CW-1:0]     ph_val;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              ce_n_q, we_n_q, oe_n_q, dq_oe_q;

  sram_pwr_gate #(.HOLD_CYC(PWR_CYC)) u_pwr (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_good (pwr_good),
    .pwr_ok   (pwr_ok)
  );

  // phase counter: length of each strobe phase
  sram_cyc_timer #(.W(CW)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ph_load),
    .load_val (ph_val),
    .zero     (ph_zero)
  );

  // minimum cycle time from acceptance to next acceptance
  sram_cyc_timer #(.W(CW)) u_cycle (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (CW'(CYC_CYC)),
    .zero     (cyc_zero)
  );

  assign req_ready = (st == ST_IDLE) && cyc_zero && pwr_ok;
  assign accept    = req_valid && req_ready;

  always_comb begin
    nxt     = st;
    ph_load = 1'b0;
    ph_val  = '0;
    unique case (st)
      ST_IDLE: if (accept) begin
        nxt     = req_write ? ST_WTURN : ST_READ;
        ph_load = 1'b1;
        ph_val  = req_write ? CW'(TURN_CYC - 1) : CW'(ACC_CYC - 1);
      end
      ST_READ: if (ph_zero) nxt = ST_IDLE;
      ST_WTURN: if (ph_zero) begin
        nxt     = ST_WPULSE;
        ph_load = 1'b1;
        ph_val  = CW'(PULSE_CYC - 1);
      end
      ST_WPULSE: if (ph_zero) begin
        nxt     = ST_WHOLD;
        ph_load = 1'b1;
        ph_val  = CW'(HOLD_CYC - 1);
      end
      ST_WHOLD: if (ph_zero) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  // state and strobes registered together so strobes never glitch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      ce_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      dq_oe_q <= 1'b0;
    end else begin
      st      <= nxt;
      ce_n_q  <= (nxt == ST_IDLE);
      oe_n_q  <= (nxt != ST_READ);
      we_n_q  <= (nxt != ST_WPULSE);
      dq_oe_q <= (nxt == ST_WPULSE) || (nxt == ST_WHOLD);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= (st == ST_READ) && ph_zero;
      if ((st == ST_READ) && ph_zero) rsp_rdata <= mem_dq_i;
    end
  end

  assign mem_addr  = addr_q;
  assign mem_dq_o  = wdata_q;
  assign mem_ce_n  = ce_n_q;
  assign mem_we_n  = we_n_q;
  assign mem_oe_n  = oe_n_q;
  assign mem_dq_oe = dq_oe_q;

  // R9
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  // R7
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> $stable(mem_addr));

  // R4
  turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> ($past(mem_oe_n) && !$past(mem_dq_oe) && !$past(mem_ce_n)));

  // R6
  we_rise_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (mem_dq_oe && !mem_ce_n && $stable(mem_addr)));

  // R8
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R3
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R2
  holdoff_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_ok && mem_ce_n) |=> (mem_ce_n || $past(accept)));

endmodule

// File: tb/sram_async_ctrl_test.sv
module sram_async_ctrl_test;

  localparam int P     = 20;
  localparam int CEIL_ACC   = (70 + P - 1) / P;
  localparam int CEIL_TURN  = (35 + P - 1) / P;
  localparam int CEIL_PULSE = (45 + P - 1) / P;
  localparam int CEIL_HOLD  = (10 + P - 1) / P;
  localparam int CEIL_PWR   = (55 + P - 1) / P;
  localparam int CEIL_CYC   = (70 + P - 1) / P;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_good = 1'b0;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [10:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_valid, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  rsp_rdata, mem_dq_o, mem_dq_i;
  logic [10:0] mem_addr;

  int total = 0;
  int bad = 0;
  logic [7:0] model [2048];

  always #(P/2) clk = ~clk;

  sram_async_ctrl uut (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_dq_i(mem_dq_i)
  );

  // behavioural memory: stores on the rising write strobe
  assign mem_dq_i = (!mem_ce_n && !mem_oe_n) ? model[mem_addr] : 8'h00;
  always @(posedge mem_we_n) if (!mem_ce_n && mem_dq_oe) model[mem_addr] <= mem_dq_o;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // strobes as a 4-bit word {ce_n, oe_n, we_n, dq_oe}
  function automatic int strb;
    return {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe};
  endfunction

  task automatic wait_ready;
    int n = 0;
    while (!req_ready && n < 50) begin @(negedge clk); n++; end
  endtask

  task automatic do_write(input logic [10:0] a, input logic [7:0] d);
    wait_ready();
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_wdata = 8'h00;
    for (int i = 0; i < CEIL_TURN; i++) begin
      chk(strb() == 4'b0110, "R4 turnaround strobes", strb(), 4'b0110);
      if (i != 0) @(negedge clk); else ;
      if (i == 0 && CEIL_TURN > 1) ; else ;
    end
    for (int i = 0; i < CEIL_PULSE; i++) begin
      @(negedge clk);
      chk(strb() == 4'b0101 && mem_dq_o == d && mem_addr == a,
          "R5 write strobe", {strb(), mem_dq_o}, {4'b0101, d});
    end
    for (int i = 0; i < CEIL_HOLD; i++) begin
      @(negedge clk);
      chk(strb() == 4'b0111 && mem_addr == a, "R6 hold after strobe",
          {strb(), mem_addr}, {4'b0111, a});
    end
    @(negedge clk);
    chk(strb() == 4'b1110, "R6 release", strb(), 4'b1110);
    chk(model[a] == d, "R5 stored byte", model[a], d);
    chk(req_ready == 1'b1, "R8 ready after write", req_ready, 1);
  endtask

  task automatic do_read(input logic [10:0] a, input logic [7:0] exp, input bit noise);
    wait_ready();
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    if (noise) begin
      req_valid = 1'b1; req_write = 1'b1; req_addr = 11'h300; req_wdata = 8'hEE;
    end else req_valid = 1'b0;
    for (int i = 0; i < CEIL_ACC; i++) begin
      if (i != 0) @(negedge clk);
      if (noise && i == CEIL_ACC - 2) req_valid = 1'b0;
      chk(strb() == 4'b0010 && mem_addr == a && !rsp_valid && !req_ready,
          "R3 read strobes", {strb(), mem_addr}, {4'b0010, a});
    end
    @(negedge clk);
    chk(rsp_valid && rsp_rdata == exp, "R3/R10 read data", {rsp_valid, rsp_rdata}, {1'b1, exp});
    chk(mem_ce_n && req_ready, "R8 ready after read", {mem_ce_n, req_ready}, 2'b11);
    @(negedge clk);
    chk(!rsp_valid, "R3 single pulse", rsp_valid, 0);
  endtask

  typedef struct packed {
    logic       wr;
    logic [10:0] a;
    logic [7:0]  d;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{1'b1, 11'h000, 8'h3C}, '{1'b1, 11'h7FF, 8'hC3}, '{1'b1, 11'h155, 8'hA5},
    '{1'b0, 11'h000, 8'h3C}, '{1'b0, 11'h7FF, 8'hC3}, '{1'b1, 11'h155, 8'h5A},
    '{1'b0, 11'h155, 8'h5A}, '{1'b1, 11'h2AA, 8'hFF}, '{1'b0, 11'h2AA, 8'hFF},
    '{1'b0, 11'h155, 8'h5A}, '{1'b1, 11'h001, 8'h00}, '{1'b0, 11'h001, 8'h00}
  };

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int i = 0; i < 2048; i++) model[i] = 8'(i) ^ 8'h5A;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk(strb() == 4'b1110 && !req_ready && !rsp_valid, "R1 reset state",
        {strb(), req_ready, rsp_valid}, {4'b1110, 2'b00});
    rst_n = 1'b1;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 11'h010;
    repeat (4) @(negedge clk);
    chk(!req_ready && mem_ce_n, "R2 no power no access", {req_ready, mem_ce_n}, 2'b01);
    req_valid = 1'b0;
    pwr_good = 1'b1;
    for (int i = 1; i < CEIL_PWR; i++) begin
      @(negedge clk);
      chk(!req_ready, "R2 hold-off", req_ready, 0);
    end
    @(negedge clk);
    chk(req_ready, "R2 hold-off end", req_ready, 1);
    pwr_good = 1'b0;
    #1;
    chk(!req_ready, "R2 power drop", req_ready, 0);
    @(negedge clk);
    pwr_good = 1'b1;
    repeat (CEIL_PWR) @(negedge clk);
    chk(req_ready, "R2 re-armed", req_ready, 1);

    foreach (VECS[k]) begin
      if (VECS[k].wr) do_write(VECS[k].a, VECS[k].d);
      else            do_read(VECS[k].a, VECS[k].d, 1'b0);
    end

    // R8: request driven while busy must be ignored
    do_read(11'h7FF, 8'hC3, 1'b1);
    repeat (2) begin
      @(negedge clk);
      chk(mem_ce_n, "R8 no access from ignored request", mem_ce_n, 1);
    end
    chk(model[11'h300] == 8'h5A, "R8 ignored write left memory", model[11'h300], 8'h5A);
    do_read(11'h300, 8'h5A, 1'b0);

    // R7/R10: write right after read, then read back
    do_read(11'h000, 8'h3C, 1'b0);
    do_write(11'h000, 8'h81);
    do_read(11'h000, 8'h81, 1'b0);
    chk(CEIL_CYC <= CEIL_TURN + CEIL_PULSE + CEIL_HOLD, "R8 cycle window", CEIL_CYC, 6);

    summary();
  end

endmodule